// File: doc/BRIEF.md
# Gamma Code Register File with Bank Switch and Deferred Load

This block stores the digital codes for a set of gamma reference channels. Two banks of registers, one code per channel in each, are filled from a simple write port that a serial decoder drives. The block presents one code per channel toward the converters and an output-enable flag for the analog drivers.

A static mode input picks how the stored codes reach the outputs. In bank mode, a select input routes either the whole first bank or the whole second bank to every channel, so a panel can flip between two prepared gamma curves in one step. In load mode, only the first bank is used. A load input either lets each write show at once or freezes every output while new codes are written, then moves all channels to their new codes together when the load input is released. A logic-supply undervoltage clears the stored codes. An output-supply undervoltage or an over-temperature flag only turns the outputs off.

Top module: `gamma_bank_regs`

## Requirements
- R1: While reset is asserted, every code output is 0 and out_en is 0; after reset every register of both banks holds 0.
- R2: A write uses wr_addr[4] to pick the bank (0 = first, 1 = second) and wr_addr[3:0] as the channel; with mode low and select low, each output shows its first-bank register, a write appearing one clock after the edge that takes it.
- R3: With mode low, the select input passes two synchronizer flops; the outputs switch to the second bank two clock edges after select rises, and back two edges after it falls.
- R4: With mode high and the synchronized load low, a first-bank write shows on its channel output at the same edge that stores it.
- R5: With mode high and the synchronized load high, writes still update the registers but every output keeps its code.
- R6: A high-to-low change of the synchronized load copies all first-bank registers to all channel outputs at one edge, three edges after the load pin falls.
- R7: A write taken at that same edge is stored but reaches its output one edge later, so all channels move together.
- R8: logic_uv clears both banks and the output latches at the next edge and drives out_en low.
- R9: drv_uv or hot drives out_en low at the next edge; register contents and codes are kept, and out_en returns high one edge after both fall.
- R10: A write to channel index 12 to 15 changes no register and no output.
- R11: With mode high, writes to the second bank have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| logic_uv | input | 1 | Logic supply undervoltage flag |
| drv_uv | input | 1 | Output supply undervoltage flag |
| hot | input | 1 | Over-temperature flag |
| upd_mode | input | 1 | 0 = bank mode, 1 = load mode (static strap) |
| bank_sel | input | 1 | Bank select, asynchronous |
| hold_ld | input | 1 | Load hold input, asynchronous |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_addr | input | 5 | Bit 4 bank, bits 3:0 channel |
| wr_data | input | 10 | Code to store |
| code_out | output | 120 | Channel codes, channel n at bits 10n+9:10n |
| out_en | output | 1 | Output enable for the drivers |

## Verification
A write is due on the outputs one edge after the edge that takes it, a select change two edges after it, and a load release three edges after the pin falls, while a write that meets the release edge shows one edge later still. Each scenario drives inputs on the falling clock edge and counts rising edges to the edge where the result is due, checking the cycle before it (still old) and the cycle of it (new). Supply and temperature flags are checked one edge after they change, along with the retained codes.

// File: rtl/gamma_regs_pkg.sv
package gamma_regs_pkg;
  localparam int NUM_CH   = 12;
  localparam int CODE_W   = 10;
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int ADDR_W   = CH_IDX_W + 1;
endpackage

// File: rtl/gamma_sync.sv
module gamma_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gamma_bank_file.sv
module gamma_bank_file #(
  parameter int NCH  = 12,
  parameter int DW   = 10,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            wr_en_i,
  input  logic            wr_bank_i,
  input  logic [CW-1:0]   wr_ch_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic [NCH*DW-1:0] bank_a_q_o,
  output logic [NCH*DW-1:0] bank_a_d_o,
  output logic [NCH*DW-1:0] bank_b_q_o
);
  localparam int TOTAL_W = NCH * DW;

  logic [TOTAL_W-1:0] bank_a_q, bank_a_d;
  logic [TOTAL_W-1:0] bank_b_q, bank_b_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_a, hit_b;
    assign hit_a = wr_en_i && !wr_bank_i && (wr_ch_i == CW'(i));
    assign hit_b = wr_en_i &&  wr_bank_i && (wr_ch_i == CW'(i));

    always_comb begin
      if (clr_i) begin
        bank_a_d[i*DW +: DW] = '0;
        bank_b_d[i*DW +: DW] = '0;
      end else begin
        bank_a_d[i*DW +: DW] = hit_a ? wr_data_i : bank_a_q[i*DW +: DW];
        bank_b_d[i*DW +: DW] = hit_b ? wr_data_i : bank_b_q[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_a_q <= '0;
      bank_b_q <= '0;
    end else begin
      bank_a_q <= bank_a_d;
      bank_b_q <= bank_b_d;
    end
  end

  assign bank_a_q_o = bank_a_q;
  assign bank_a_d_o = bank_a_d;
  assign bank_b_q_o = bank_b_q;

  // R8: a clear empties both banks at the next edge
  p_clear_banks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bank_a_q == '0 && bank_b_q == '0));

  // R10: channel indices past the last channel touch nothing
  p_bad_index_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (int'(wr_ch_i) >= NCH) && !clr_i) |=> ($stable(bank_a_q) && $stable(bank_b_q)));
endmodule

// File: rtl/gamma_out_stage.sv
module gamma_out_stage #(
  parameter int NCH = 12,
  parameter int DW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              mode_i,
  input  logic              sel_s_i,
  input  logic              ld_s_i,
  input  logic [NCH*DW-1:0] bank_a_q_i,
  input  logic [NCH*DW-1:0] bank_a_d_i,
  input  logic [NCH*DW-1:0] bank_b_q_i,
  output logic [NCH*DW-1:0] code_o
);
  localparam int TOTAL_W = NCH * DW;

  logic               ld_prev_q;
  logic               ld_fall;
  logic [TOTAL_W-1:0] latch_q, latch_d;

  assign ld_fall = ld_prev_q && !ld_s_i;

  always_comb begin
    if (clr_i)        latch_d = '0;
    else if (ld_fall) latch_d = bank_a_q_i;
    else if (ld_s_i)  latch_d = latch_q;
    else              latch_d = bank_a_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q <= 1'b0;
      latch_q   <= '0;
    end else begin
      ld_prev_q <= ld_s_i;
      latch_q   <= latch_d;
    end
  end

  always_comb begin
    if (mode_i)       code_o = latch_q;
    else if (sel_s_i) code_o = bank_b_q_i;
    else              code_o = bank_a_q_i;
  end

  // R5: while load is held, the output latches keep their codes
  p_hold_keeps_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_s_i && !ld_fall && !clr_i) |=> $stable(latch_q));

  // R6: on the release edge every latch takes the stored first-bank code
  p_release_copies_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fall && !clr_i) |=> (latch_q == $past(bank_a_q_i)));
endmodule

// File: rtl/gamma_bank_regs.sv
module gamma_bank_regs
  import gamma_regs_pkg::*;
#(
  parameter int NCH = NUM_CH,
  parameter int DW  = CODE_W,
  parameter int CW  = CH_IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              logic_uv,
  input  logic              drv_uv,
  input  logic              hot,
  input  logic              upd_mode,
  input  logic              bank_sel,
  input  logic              hold_ld,
  input  logic              wr_en,
  input  logic [CW:0]       wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] code_out,
  output logic              out_en
);
  localparam int TOTAL_W = NCH * DW;

  logic [1:0]         ctl_s;
  logic [TOTAL_W-1:0] bank_a_q, bank_a_d, bank_b_q;
  logic               en_d, en_q;

  gamma_sync #(.WIDTH(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({hold_ld, bank_sel}),
    .sync_o  (ctl_s)
  );

  gamma_bank_file #(.NCH(NCH), .DW(DW), .CW(CW)) u_banks (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (logic_uv),
    .wr_en_i    (wr_en),
    .wr_bank_i  (wr_addr[CW]),
    .wr_ch_i    (wr_addr[CW-1:0]),
    .wr_data_i  (wr_data),
    .bank_a_q_o (bank_a_q),
    .bank_a_d_o (bank_a_d),
    .bank_b_q_o (bank_b_q)
  );

  gamma_out_stage #(.NCH(NCH), .DW(DW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (logic_uv),
    .mode_i     (upd_mode),
    .sel_s_i    (ctl_s[0]),
    .ld_s_i     (ctl_s[1]),
    .bank_a_q_i (bank_a_q),
    .bank_a_d_i (bank_a_d),
    .bank_b_q_i (bank_b_q),
    .code_o     (code_out)
  );

  assign en_d = !(logic_uv || drv_uv || hot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign out_en = en_q;

  // R9: any fault flag turns the drivers off at the next edge
  p_fault_disables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_uv || drv_uv || hot) |=> !out_en);

  // R9: with no flag the drivers are on at the next edge
  p_clean_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(logic_uv || drv_uv || hot) |=> out_en);
endmodule

// File: tb/sim_gamma_bank_regs.sv
module sim_gamma_bank_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 12;
  localparam int DW  = 10;

  logic clk = 1'b0;
  logic rst_n, logic_uv, drv_uv, hot, upd_mode, bank_sel, hold_ld, wr_en;
  logic [4:0]        wr_addr;
  logic [DW-1:0]     wr_data;
  logic [NCH*DW-1:0] code_out;
  logic              out_en;

  logic [NCH*DW-1:0] ea, eb, snap;
  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_bank_regs u0 (
    .clk(clk), .rst_n(rst_n), .logic_uv(logic_uv), .drv_uv(drv_uv), .hot(hot),
    .upd_mode(upd_mode), .bank_sel(bank_sel), .hold_ld(hold_ld), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .code_out(code_out), .out_en(out_en)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [NCH*DW-1:0] exp);
    for (int c = 0; c < NCH; c++)
      chk($sformatf("%s ch%0d", req, c), int'(code_out[c*DW +: DW]), int'(exp[c*DW +: DW]));
  endtask

  // single write, updates the model, returns one edge later at a falling edge
  task automatic wr(input logic bank, input int ch, input logic [DW-1:0] d);
    wr_en = 1'b1;
    wr_addr = {bank, 4'(ch)};
    wr_data = d;
    if (ch < NCH) begin
      if (bank) eb[ch*DW +: DW] = d;
      else      ea[ch*DW +: DW] = d;
    end
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; logic_uv = 0; drv_uv = 0; hot = 0; upd_mode = 0;
    bank_sel = 0; hold_ld = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    ea = '0; eb = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_en in reset", int'(out_en), 0);
    chk_vec("R1 codes in reset", '0);
    rst_n = 1'b1;
    tick();
    chk("R9 out_en after reset", int'(out_en), 1);
    chk_vec("R1 codes after reset", '0);
  endtask

  task automatic t_bank_a();
    wr(0, 0, 10'h3FC);
    chk("R2 ch0 next edge", int'(code_out[0 +: DW]), 'h3FC);
    wr(0, 11, 10'h051);
    wr(0, 6, 10'h1E8);
    wr(1, 0, 10'h155);
    wr(1, 6, 10'h2AA);
    wr(1, 11, 10'h3FF);
    chk_vec("R2 bank A shown", ea);
  endtask

  task automatic t_bank_b();
    bank_sel = 1'b1;
    tick();
    chk_vec("R3 one edge after select", ea);
    tick();
    chk_vec("R3 two edges after select", eb);
    bank_sel = 1'b0;
    tick();
    chk_vec("R3 one edge after deselect", eb);
    tick();
    chk_vec("R3 two edges after deselect", ea);
  endtask

  task automatic t_bad_index();
    wr(0, 12, 10'h111);
    wr(0, 15, 10'h222);
    chk_vec("R10 bank A untouched", ea);
    bank_sel = 1'b1;
    wr(1, 13, 10'h333);
    tick();
    chk_vec("R10 bank B untouched", eb);
    bank_sel = 1'b0;
    tick(); tick();
  endtask

  task automatic t_live_load();
    upd_mode = 1'b1;
    #1;
    chk_vec("R4 latch follows bank A", ea);
    wr(0, 3, 10'h0C3);
    chk("R4 ch3 at storing edge", int'(code_out[3*DW +: DW]), 'h0C3);
    wr(1, 3, 10'h3C0);
    chk_vec("R11 bank B write invisible", ea);
  endtask

  task automatic t_hold_release();
    hold_ld = 1'b1;
    tick(); tick(); tick();
    snap = ea;
    wr(0, 1, 10'h101);
    wr(0, 4, 10'h204);
    wr(0, 9, 10'h309);
    chk_vec("R5 outputs held", snap);
    hold_ld = 1'b0;
    tick();
    chk_vec("R5 held one edge after release", snap);
    tick();
    chk_vec("R6 held two edges after release", snap);
    snap = ea;
    wr(0, 5, 10'h255);
    chk_vec("R6 all channels updated together", snap);
    tick();
    chk("R7 coincident write one edge later", int'(code_out[5*DW +: DW]), 'h255);
    chk_vec("R7 final state", ea);
  endtask

  task automatic t_faults();
    drv_uv = 1'b1;
    tick();
    chk("R9 drv_uv disables", int'(out_en), 0);
    drv_uv = 1'b0;
    tick();
    chk("R9 enable after drv_uv", int'(out_en), 1);
    chk_vec("R9 codes kept", ea);
    hot = 1'b1;
    tick();
    chk("R9 hot disables", int'(out_en), 0);
    hot = 1'b0;
    tick();
    chk("R9 enable after hot", int'(out_en), 1);
  endtask

  task automatic t_logic_uv();
    logic_uv = 1'b1;
    ea = '0; eb = '0;
    tick();
    chk("R8 out_en low", int'(out_en), 0);
    chk_vec("R8 latches cleared", '0);
    logic_uv = 1'b0;
    upd_mode = 1'b0;
    bank_sel = 1'b1;
    tick(); tick();
    chk("R8 out_en back", int'(out_en), 1);
    chk_vec("R8 bank B cleared", '0);
    bank_sel = 1'b0;
    tick(); tick();
    chk_vec("R8 bank A cleared", '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_bank_a();
    t_bank_b();
    t_bad_index();
    t_live_load();
    t_hold_release();
    t_faults();
    t_logic_uv();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule